// File: doc/BRIEF.md
# Satellite-Second Disciplined Time-of-Day Counter

This block keeps a nanosecond time-of-day count for packet stamping logic. On every clock, nominally 100 MHz, it adds a fixed-point increment to a wide accumulator. The increment has a 10 ns integer part and 32 fractional bits, and the whole-nanosecond part of the accumulator is the timestamp. A once-per-second pulse from a satellite timing receiver is the reference. The block synchronises that pulse and, on each rising edge, compares the nanoseconds counted since the previous edge against one nominal second.

Each such difference is added to a signed running total. The increment is then rebuilt from the nominal value minus the running total, scaled by a programmable right-shift gain, and held inside a ±100 ppm band. A lock indicator rises after a run of small errors. If the reference goes quiet for one and a half seconds of counted time, the block keeps its last rate, drops the lock and waits for a fresh edge to re-arm.

The length of a "second" is a parameter, so a shortened second can be used where a full one is impractical.

Top module: `pps_timebase`

## Requirements
- R1: While reset is asserted, the timestamp reads 0, the rate output reads the nominal increment (10 shifted left by 32) and locked is 0.
- R2: Each clock the 32-fractional-bit accumulator grows by the current increment; at the nominal rate the timestamp rises by exactly 10 per clock.
- R3: The reference pulse passes through a two-stage synchroniser and a rising-edge detector. A rising edge acts on the third clock after it is applied, and a pulse held high for many clocks counts as one edge.
- R4: The first edge after reset, or after a timeout, only records the timestamp. It changes neither the rate nor the lock state.
- R5: On every later edge, the error is the timestamp difference between this edge and the previous one minus SEC_NS. The error is added to a signed running sum, and a zero error leaves the rate unchanged.
- R6: On each such edge the new increment is the nominal increment minus ((sum × 2^32) arithmetically shifted right by gainShift).
- R7: The increment is clamped to nominal ± floor(nominal × 100 / 1,000,000). At default widths that is 42949672960 ± 4294967.
- R8: Locked rises on the third consecutive update whose error magnitude is below lockThresh. An update whose error magnitude is at or above lockThresh clears both locked and the run count.
- R9: While armed, if the counted time since the last edge exceeds 1.5 × SEC_NS, locked clears, the increment is held and the block disarms.
- R10: The increment register changes only on an update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, nominally 100 MHz |
| rst | input | 1 | Synchronous reset, active high |
| ppsIn | input | 1 | Asynchronous once-per-second reference pulse |
| gainShift | input | 6 | Right-shift applied to the scaled error sum |
| lockThresh | input | 32 | Error magnitude, in ns, below which a second counts as good |
| timeNs | output | 64 | Current timestamp in whole nanoseconds |
| rateInc | output | 40 | Current per-clock increment, 32 fractional bits |
| locked | output | 1 | Rate has settled against the reference |

## Verification
A corrupted running sum or increment shows on rateInc three clocks after the reference edge that applies it. From the following clock it also shows as a wrong slope of timeNs, so one second later the measured error is visibly off. A synchroniser or edge detector that fires more than once turns a pulse into a near-zero interval whose error pins the rate to a clamp edge. A lost or miscounted run of good seconds shows on locked at the third edge. A missing timeout leaves locked high well past one and a half nominal seconds of silence.

// File: rtl/pps_timebase_pkg.sv
`timescale 1ns/1ps
package pps_timebase_pkg;
  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic capture;  // record timestamp of this reference edge
    logic update;   // fold the measured error into sum and rate
  } discStrobe_t;
endpackage

// File: rtl/pps_timebase_dp.sv
`timescale 1ns/1ps
module pps_timebase_dp
  import pps_timebase_pkg::*;
#(
  parameter int TS_W      = 64,
  parameter int FRAC_W    = 32,
  parameter int SUM_W     = 40,
  parameter int GAIN_W    = 6,
  parameter int THR_W     = 32,
  parameter int NOM_NS    = 10,
  parameter int SEC_NS    = 1000000000,
  parameter int LIMIT_PPM = 100,
  localparam int INC_W    = FRAC_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  discStrobe_t       strobe,
  input  logic [GAIN_W-1:0] gainShift,
  input  logic [THR_W-1:0]  lockThresh,
  output logic [TS_W-1:0]   timeNs,
  output logic [INC_W-1:0]  rateInc,
  output logic              overdue,
  output logic              errSmall
);
  localparam int ACC_W  = TS_W + FRAC_W;
  localparam int WIDE_W = SUM_W + FRAC_W + 1;
  localparam logic [63:0] NOM_L = 64'(NOM_NS) << FRAC_W;
  localparam logic [63:0] LIM_L = NOM_L * 64'(LIMIT_PPM) / 64'd1000000;
  localparam logic [INC_W-1:0] NOM_INC = INC_W'(NOM_L);
  localparam logic [INC_W-1:0] MIN_INC = INC_W'(NOM_L - LIM_L);
  localparam logic [INC_W-1:0] MAX_INC = INC_W'(NOM_L + LIM_L);
  localparam logic [TS_W-1:0]  TIMEOUT_NS = TS_W'(64'(SEC_NS) + 64'(SEC_NS) / 64'd2);

  logic [ACC_W-1:0]        accQ;
  logic [INC_W-1:0]        incQ;
  logic [TS_W-1:0]         edgeStamp;
  logic signed [SUM_W-1:0] sumQ;

  logic [TS_W-1:0]          elapsed;
  logic signed [SUM_W-1:0]  errVal, errMag, nextSum;
  logic signed [WIDE_W-1:0] scaledIn, scaled, rawInc, minW, maxW;
  logic [INC_W-1:0]         clampedInc;

  assign timeNs  = accQ[ACC_W-1:FRAC_W];
  assign rateInc = incQ;
  assign elapsed = timeNs - edgeStamp;
  assign overdue = elapsed > TIMEOUT_NS;

  always_comb begin
    errVal   = $signed(elapsed[SUM_W-1:0]) - $signed(SUM_W'(SEC_NS));
    errMag   = (errVal < 0) ? -errVal : errVal;
    errSmall = $unsigned(errMag) < SUM_W'(lockThresh);
    nextSum  = sumQ + errVal;
    scaledIn = {nextSum[SUM_W-1], nextSum, {FRAC_W{1'b0}}};
    scaled   = scaledIn >>> gainShift;
    minW     = $signed({{(WIDE_W-INC_W){1'b0}}, MIN_INC});
    maxW     = $signed({{(WIDE_W-INC_W){1'b0}}, MAX_INC});
    rawInc   = $signed({{(WIDE_W-INC_W){1'b0}}, NOM_INC}) - scaled;
    if (rawInc < minW)      clampedInc = MIN_INC;
    else if (rawInc > maxW) clampedInc = MAX_INC;
    else                    clampedInc = rawInc[INC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ      <= '0;
      incQ      <= NOM_INC;
      edgeStamp <= '0;
      sumQ      <= '0;
    end else begin
      accQ <= accQ + ACC_W'(incQ);
      if (strobe.capture) edgeStamp <= timeNs;
      if (strobe.update) begin
        sumQ <= nextSum;
        incQ <= clampedInc;
      end
    end
  end

  // R7: the rate never leaves the permitted band
  assert_rate_in_band_R7: assert property (@(posedge clk) disable iff (rst)
    (rateInc >= MIN_INC) && (rateInc <= MAX_INC));

  // R10: without an update the rate register keeps its value
  assert_rate_held_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(strobe.update)) |-> $stable(rateInc));

  // R2: the timestamp grows by the integer part of the increment, plus a carry
  assert_time_step_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((timeNs - $past(timeNs)) == TS_W'($past(rateInc) >> FRAC_W)) ||
                    ((timeNs - $past(timeNs)) == TS_W'(($past(rateInc) >> FRAC_W) + 1)));
endmodule

// File: rtl/pps_timebase_ctrl.sv
`timescale 1ns/1ps
module pps_timebase_ctrl
  import pps_timebase_pkg::*;
#(
  parameter int LOCK_COUNT = 3,
  localparam int CNT_W     = $clog2(LOCK_COUNT + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ppsIn,
  input  logic        overdue,
  input  logic        errSmall,
  output discStrobe_t strobe,
  output logic        locked
);
  logic [1:0]       syncQ;
  logic             ppsPrev;
  logic             ppsEdge;
  logic             armed;
  logic [CNT_W-1:0] goodCnt;

  assign ppsEdge        = syncQ[1] & ~ppsPrev;
  assign strobe.capture = ppsEdge;
  assign strobe.update  = ppsEdge & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '0;
      ppsPrev <= 1'b0;
      armed   <= 1'b0;
      goodCnt <= '0;
      locked  <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], ppsIn};
      ppsPrev <= syncQ[1];
      if (ppsEdge) begin
        armed <= 1'b1;
        if (armed) begin
          if (errSmall) begin
            if (goodCnt != CNT_W'(LOCK_COUNT)) goodCnt <= goodCnt + 1'b1;
            if (goodCnt >= CNT_W'(LOCK_COUNT - 1)) locked <= 1'b1;
          end else begin
            goodCnt <= '0;
            locked  <= 1'b0;
          end
        end
      end else if (armed && overdue) begin
        armed   <= 1'b0;
        goodCnt <= '0;
        locked  <= 1'b0;
      end
    end
  end

  // R8: lock is only ever gained on an update edge
  assert_lock_on_update_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(strobe.update));

  // R3: a reference edge is a single-clock event
  assert_single_event_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> !strobe.capture);

  // R9: silence past the limit drops lock
  assert_timeout_unlock_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && overdue && !ppsEdge) |=> !locked);
endmodule

// File: rtl/pps_timebase.sv
`timescale 1ns/1ps
module pps_timebase
  import pps_timebase_pkg::*;
#(
  parameter int TS_W       = 64,
  parameter int FRAC_W     = 32,
  parameter int SUM_W      = 40,
  parameter int GAIN_W     = 6,
  parameter int THR_W      = 32,
  parameter int NOM_NS     = 10,
  parameter int SEC_NS     = 1000000000,
  parameter int LIMIT_PPM  = 100,
  parameter int LOCK_COUNT = 3,
  localparam int INC_W     = FRAC_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ppsIn,
  input  logic [GAIN_W-1:0] gainShift,
  input  logic [THR_W-1:0]  lockThresh,
  output logic [TS_W-1:0]   timeNs,
  output logic [INC_W-1:0]  rateInc,
  output logic              locked
);
  discStrobe_t strobe;
  logic        overdue;
  logic        errSmall;

  pps_timebase_ctrl #(.LOCK_COUNT(LOCK_COUNT)) i_ctrl (
    .clk(clk), .rst(rst), .ppsIn(ppsIn), .overdue(overdue),
    .errSmall(errSmall), .strobe(strobe), .locked(locked)
  );

  pps_timebase_dp #(
    .TS_W(TS_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W), .GAIN_W(GAIN_W),
    .THR_W(THR_W), .NOM_NS(NOM_NS), .SEC_NS(SEC_NS), .LIMIT_PPM(LIMIT_PPM)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .gainShift(gainShift),
    .lockThresh(lockThresh), .timeNs(timeNs), .rateInc(rateInc),
    .overdue(overdue), .errSmall(errSmall)
  );
endmodule

// File: tb/test_pps_timebase.sv
`timescale 1ns/1ps
module test_pps_timebase;
  localparam logic [63:0] NOM = 64'd10 << 32;
  localparam logic [63:0] LIM = NOM * 64'd100 / 64'd1000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ppsIn = 1'b0;
  logic [5:0]  gainShift = 6'd16;
  logic [31:0] lockThresh = 32'd5;
  logic [63:0] timeNs;
  logic [39:0] rateInc;
  logic        locked;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    string       tag;
    logic [63:0] inc;
    logic        lock;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  pps_timebase #(.SEC_NS(10000)) i_pps_timebase (
    .clk(clk), .rst(rst), .ppsIn(ppsIn), .gainShift(gainShift),
    .lockThresh(lockThresh), .timeNs(timeNs), .rateInc(rateInc), .locked(locked)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_state(string tag, logic [63:0] inc, logic lock);
    exp_t item;
    item.tag = tag;
    item.inc = inc;
    item.lock = lock;
    expQ.push_back(item);
  endtask

  // monitor: compare rate and lock against the queued expectation
  initial begin
    forever begin
      exp_t item;
      wait (expQ.size() > 0);
      item = expQ.pop_front();
      check({item.tag, " rate"}, {24'd0, rateInc}, item.inc);
      check({item.tag, " lock"}, {63'd0, locked}, {63'd0, item.lock});
    end
  end

  // rising reference edge 'gap' clocks after the previous one; returns 4 clocks after it
  task automatic ppsEdge(int gap);
    repeat (gap - 4) @(negedge clk);
    ppsIn = 1'b1;
    repeat (2) @(negedge clk);
    ppsIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    ppsIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 time", timeNs, 64'd0);
    check("R1 rate", {24'd0, rateInc}, NOM);
    check("R1 lock", {63'd0, locked}, 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [63:0] t0;
    // scenario: nominal count, lock and update arithmetic
    gainShift = 6'd16;
    lockThresh = 32'd5;
    doReset();
    @(negedge clk);
    t0 = timeNs;
    repeat (50) @(negedge clk);
    check("R2 nominal advance", timeNs - t0, 64'd500);
    ppsEdge(10);
    expect_state("R4 first edge arms only", NOM, 1'b0);
    ppsEdge(1000);
    expect_state("R5 zero error sec1", NOM, 1'b0);
    ppsEdge(1000);
    expect_state("R5 zero error sec2", NOM, 1'b0);
    ppsEdge(1000);
    expect_state("R8 lock on third good", NOM, 1'b1);
    ppsEdge(1001);
    expect_state("R6 err+10 gain16 / R8 bad clears", NOM - 64'd655360, 1'b0);
    ppsEdge(1000);
    expect_state("R6 err-1 sum9", NOM - 64'd589824, 1'b0);

    // scenario: clamp both ways
    wait (expQ.size() == 0);
    gainShift = 6'd0;
    doReset();
    ppsEdge(10);
    expect_state("R4 arm after reset", NOM, 1'b0);
    ppsEdge(1001);
    expect_state("R7 low clamp", NOM - LIM, 1'b0);
    ppsEdge(990);
    expect_state("R7 high clamp", NOM + LIM, 1'b0);

    // scenario: lock with nonzero errors, then timeout and re-arm
    wait (expQ.size() == 0);
    gainShift = 6'd16;
    lockThresh = 32'd50;
    doReset();
    ppsEdge(10);
    expect_state("R4 arm", NOM, 1'b0);
    ppsEdge(1001);
    expect_state("R8 good1", NOM - 64'd655360, 1'b0);
    ppsEdge(1000);
    expect_state("R8 good2", NOM - 64'd589824, 1'b0);
    ppsEdge(1000);
    expect_state("R8 good3 locks", NOM - 64'd589824, 1'b1);
    repeat (1700) @(negedge clk);
    expect_state("R9 timeout holds rate and unlocks", NOM - 64'd589824, 1'b0);
    ppsEdge(300);
    expect_state("R4 re-arm after timeout", NOM - 64'd589824, 1'b0);

    // scenario: long high pulse is one event
    wait (expQ.size() == 0);
    doReset();
    ppsEdge(10);
    repeat (996) @(negedge clk);
    ppsIn = 1'b1;
    repeat (600) @(negedge clk);
    expect_state("R3 long pulse counts once", NOM, 1'b0);
    ppsIn = 1'b0;
    repeat (2) @(negedge clk);
    t0 = timeNs;
    repeat (20) @(negedge clk);
    check("R2 advance after update", timeNs - t0, 64'd200);

    wait (expQ.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule